// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block collects requests from four system exception sources and from a parameterised number of external interrupt lines. It picks the one pending, enabled source that is most urgent and offers its exception number to a processor core as a registered request. Each external line has an enable bit and a programmable priority. Two of the system sources also have a programmable priority. The other two system sources have fixed levels that beat every programmable one. All of these settings live in a small word-addressed register file.

The core takes a request by pulsing an acknowledge with the exception number. This clears that source's pending bit and marks it active. When the handler finishes, a completion pulse with the same number clears the active mark. The block tracks the most urgent level among the active sources. A new request is offered only when it is strictly more urgent than that level, which gives nested preemption.

Top module: `irq_ctrl`

## Requirements
- R1: After a synchronous active-low reset nothing is pending or active, `irq_valid` is 0, `irq_num` is 0, every enable and priority field reads 0, and `active_level` is all ones.
- R2: External line n is reported as exception number 16+n. System inputs `sys_req[0..3]` are reported as 2, 3, 11 and 15. Number 0 is never reported.
- R3: A source becomes pending only on a rising edge of its request input. A request held high after its acknowledge does not pend again.
- R4: An external line whose enable bit is 0 is never offered. If it is still pending when its bit is set to 1, it is offered.
- R5: Among eligible pending sources the smaller priority value wins. On equal values the lower exception number wins.
- R6: `sys_req[0]` (level 0) and `sys_req[1]` (level 1) have fixed levels above every programmable level, and `sys_req[0]` beats `sys_req[1]`. A programmable priority p is level p+2 on `active_level`. The idle value is all ones.
- R7: Register map, word addressed. At address w (0 to 7), bit b is the enable of line 32w+b. At address 0x10+w, byte k (bits 8k+7:8k) holds the priority of line 4w+k in its low PRIO_BITS bits. At address 0x60, bits [7:0] hold the priority of exception 11 and bits [15:8] hold the priority of exception 15, each in the low PRIO_BITS bits. Unused bits and unmapped addresses read 0. Reads are combinational.
- R8: A priority rewrite is used by the next arbitration. The offered source changes within two clock edges of the write.
- R9: An acknowledge of a pending source's number clears its pending bit and marks it active. `active_level` is the most urgent level among active sources. A completion pulse with that number clears the active mark.
- R10: A source is offered only if its level is strictly smaller than `active_level`. An equal level waits.
- R11: `irq_valid` and `irq_num` are registered. They reflect a request edge by the second clock edge after the request is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sys_req | input | 4 | System exception request levels |
| ext_req | input | NUM_EXT | External interrupt request levels |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| ack_valid | input | 1 | Core takes an exception |
| ack_num | input | 8 | Exception number being taken |
| done_valid | input | 1 | Core finished a handler |
| done_num | input | 8 | Exception number finished |
| irq_valid | output | 1 | Request to the core |
| irq_num | output | 8 | Exception number offered (0 when idle) |
| active_level | output | PRIO_BITS+2 | Most urgent level currently active |

## Verification
On every cycle the assertions check the following:
- An offered number is never zero.
- An offered level is strictly below the active level of the cycle before.
- The arbiter's choice is pending and enabled.
- A held request never pends again.
- An acknowledge clears pending and sets active.
- Register writes land in the addressed field.

Only the bench's scenarios can show the rest:
- The tie-break by exception number.
- The dominance of the fixed system levels.
- Delayed enabling of a pending line.
- The effect of a priority rewrite on the next choice.
- The nested ack/done sequence checked against an independent reference model.

// File: rtl/irq_ctrl_pkg.sv
// Shared constants, types and helpers for the interrupt controller.
// Assumes exactly four system sources and 8-bit exception numbers.
package irq_ctrl_pkg;

    localparam int          SYS_SRC       = 4;
    localparam int          NUM_W         = 8;
    localparam int          EXT_BASE      = 16;
    localparam logic [7:0]  EN_BASE       = 8'h00;
    localparam logic [7:0]  PRIO_BASE     = 8'h10;
    localparam logic [7:0]  SYS_PRIO_ADDR = 8'h60;

    typedef enum logic [1:0] {
        REG_ENABLE,
        REG_PRIO,
        REG_SYSPRIO,
        REG_NONE
    } reg_region_e;

    // Exception number of system source idx
    function automatic logic [NUM_W-1:0] sys_number(input int idx);
        case (idx)
            0:       return 8'd2;
            1:       return 8'd3;
            2:       return 8'd11;
            default: return 8'd15;
        endcase
    endfunction

    // Classify a word address into a register region
    function automatic reg_region_e addr_region(input logic [7:0] addr,
                                                input int en_words,
                                                input int prio_words);
        if (addr < EN_BASE + 8'(en_words))
            return REG_ENABLE;
        else if (addr >= PRIO_BASE && addr < PRIO_BASE + 8'(prio_words))
            return REG_PRIO;
        else if (addr == SYS_PRIO_ADDR)
            return REG_SYSPRIO;
        else
            return REG_NONE;
    endfunction

endpackage

// File: rtl/irq_regs.sv
// Register file: enable bits and priority fields for external lines, plus
// programmable priorities of two system sources. Word addressed, writes
// take effect on the clock edge, reads are combinational.
module irq_regs
    import irq_ctrl_pkg::*;
#(
    parameter int NUM_EXT   = 8,
    parameter int PRIO_BITS = 3
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 we,
    input  logic [7:0]                           addr,
    input  logic [31:0]                          wdata,
    output logic [31:0]                          rdata,
    output logic [NUM_EXT-1:0]                   ext_en,
    output logic [NUM_EXT-1:0][PRIO_BITS-1:0]    ext_prio,
    output logic [1:0][PRIO_BITS-1:0]            sys_prio
);

    localparam int EN_WORDS   = (NUM_EXT + 31) / 32;
    localparam int PRIO_WORDS = (NUM_EXT + 3) / 4;

    reg_region_e region;
    logic        wdata_unused;

    assign region       = addr_region(addr, EN_WORDS, PRIO_WORDS);
    assign wdata_unused = ^wdata;

    for (genvar n = 0; n < NUM_EXT; n++) begin : g_line
        localparam logic [7:0] EN_ADDR = EN_BASE + 8'(n / 32);
        localparam logic [7:0] PR_ADDR = PRIO_BASE + 8'(n / 4);
        localparam int         EN_BIT  = n % 32;
        localparam int         PR_LSB  = 8 * (n % 4);

        // Per-line enable bit update
        always_ff @(posedge clk) begin
            if (!rst_n)
                ext_en[n] <= 1'b0;
            else if (we && addr == EN_ADDR)
                ext_en[n] <= wdata[EN_BIT];
        end

        // Per-line priority field update
        always_ff @(posedge clk) begin
            if (!rst_n)
                ext_prio[n] <= '0;
            else if (we && addr == PR_ADDR)
                ext_prio[n] <= wdata[PR_LSB +: PRIO_BITS];
        end
    end

    // Programmable system priorities
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sys_prio <= '0;
        end else if (we && addr == SYS_PRIO_ADDR) begin
            sys_prio[0] <= wdata[PRIO_BITS-1:0];
            sys_prio[1] <= wdata[8 +: PRIO_BITS];
        end
    end

    // Read multiplexer
    always_comb begin
        rdata = '0;
        unique case (region)
            REG_ENABLE: begin
                for (int n = 0; n < NUM_EXT; n++)
                    if (addr == EN_BASE + 8'(n / 32))
                        rdata[n % 32] = ext_en[n];
            end
            REG_PRIO: begin
                for (int n = 0; n < NUM_EXT; n++)
                    if (addr == PRIO_BASE + 8'(n / 4))
                        rdata[8 * (n % 4) +: PRIO_BITS] = ext_prio[n];
            end
            REG_SYSPRIO: begin
                rdata[PRIO_BITS-1:0]  = sys_prio[0];
                rdata[8 +: PRIO_BITS] = sys_prio[1];
            end
            default: rdata = '0;
        endcase
    end

    // R7: an enable write reaches line 0 on the next cycle
    a_r7_en_write: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == EN_BASE) |=> (ext_en[0] == $past(wdata[0])));

    // R7: a system priority write reaches the field on the next cycle
    a_r7_sys_write: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == SYS_PRIO_ADDR) |=> (sys_prio[0] == $past(wdata[PRIO_BITS-1:0])));

endmodule

// File: rtl/irq_state.sv
// Pending and active bookkeeping per source: edge detection on request
// levels, clear-on-acknowledge, active mark until completion.
// Assumes src_num holds distinct exception numbers.
module irq_state #(
    parameter int NSRC  = 12,
    parameter int NUM_W = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NSRC-1:0]             src_req,
    input  logic [NSRC-1:0][NUM_W-1:0]  src_num,
    input  logic                        ack_valid,
    input  logic [NUM_W-1:0]            ack_num,
    input  logic                        done_valid,
    input  logic [NUM_W-1:0]            done_num,
    output logic [NSRC-1:0]             pending,
    output logic [NSRC-1:0]             active
);

    logic [NSRC-1:0] req_q;
    logic [NSRC-1:0] rise;
    logic [NSRC-1:0] hit_ack;
    logic [NSRC-1:0] hit_done;

    // Previous request level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n)
            req_q <= '0;
        else
            req_q <= src_req;
    end

    assign rise = src_req & ~req_q;

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        assign hit_ack[i]  = ack_valid && (ack_num == src_num[i]) && pending[i];
        assign hit_done[i] = done_valid && (done_num == src_num[i]);

        // Pending: set on request edge, cleared when taken
        always_ff @(posedge clk) begin
            if (!rst_n)
                pending[i] <= 1'b0;
            else if (rise[i])
                pending[i] <= 1'b1;
            else if (hit_ack[i])
                pending[i] <= 1'b0;
        end

        // Active: set when taken, cleared on completion
        always_ff @(posedge clk) begin
            if (!rst_n)
                active[i] <= 1'b0;
            else if (hit_ack[i])
                active[i] <= 1'b1;
            else if (hit_done[i])
                active[i] <= 1'b0;
        end
    end

    // R3: a level held high never pends again
    a_r3_no_repend: assert property (@(posedge clk) disable iff (!rst_n)
        (!pending[0] && req_q[0] && src_req[0]) |=> !pending[0]);

    // R9: acknowledge of a pending source clears pending and sets active
    a_r9_ack_moves: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && ack_num == src_num[0] && pending[0] && !(src_req[0] && !req_q[0]))
        |=> (!pending[0] && active[0]));

endmodule

// File: rtl/irq_pick.sv
// Combinational selector: finds the candidate with the smallest level;
// on equal levels the lowest index wins. Level output is 0 when none.
module irq_pick #(
    parameter int N  = 12,
    parameter int W  = 5,
    parameter int IW = 4
) (
    input  logic [N-1:0]         cand,
    input  logic [N-1:0][W-1:0]  lvl,
    output logic                 found,
    output logic [IW-1:0]        idx,
    output logic [W-1:0]         best
);

    // Linear scan in index order, strict compare keeps the lower index
    always_comb begin
        found = 1'b0;
        idx   = '0;
        best  = '0;
        for (int i = 0; i < N; i++) begin
            if (cand[i] && (!found || lvl[i] < best)) begin
                found = 1'b1;
                idx   = IW'(i);
                best  = lvl[i];
            end
        end
    end

endmodule

// File: rtl/irq_ctrl.sv
// Vectored priority interrupt controller top. Maps sources to exception
// numbers and levels, arbitrates pending sources and active sources,
// and registers the request to the core. Assumes 1 <= NUM_EXT <= 240 and
// 1 <= PRIO_BITS <= 8.
module irq_ctrl
    import irq_ctrl_pkg::*;
#(
    parameter int NUM_EXT   = 8,
    parameter int PRIO_BITS = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [3:0]             sys_req,
    input  logic [NUM_EXT-1:0]     ext_req,
    input  logic                   reg_we,
    input  logic [7:0]             reg_addr,
    input  logic [31:0]            reg_wdata,
    output logic [31:0]            reg_rdata,
    input  logic                   ack_valid,
    input  logic [7:0]             ack_num,
    input  logic                   done_valid,
    input  logic [7:0]             done_num,
    output logic                   irq_valid,
    output logic [7:0]             irq_num,
    output logic [PRIO_BITS+1:0]   active_level
);

    localparam int NSRC  = SYS_SRC + NUM_EXT;
    localparam int LVL_W = PRIO_BITS + 2;
    localparam int IDX_W = $clog2(NSRC);

    logic [NUM_EXT-1:0]                ext_en;
    logic [NUM_EXT-1:0][PRIO_BITS-1:0] ext_prio;
    logic [1:0][PRIO_BITS-1:0]         sys_prio;

    logic [NSRC-1:0]              src_req;
    logic [NSRC-1:0][NUM_W-1:0]   src_num;
    logic [NSRC-1:0][LVL_W-1:0]   src_lvl;
    logic [NSRC-1:0]              src_en;
    logic [NSRC-1:0]              pending;
    logic [NSRC-1:0]              active;

    logic                sel_found, act_found;
    logic [IDX_W-1:0]    sel_idx, act_idx;
    logic [LVL_W-1:0]    sel_lvl, act_lvl;
    logic                offer;
    logic [LVL_W-1:0]    irq_lvl_q;

    assign src_req = {ext_req, sys_req};

    // Source attribute mapping: number, level, eligibility
    for (genvar i = 0; i < NSRC; i++) begin : g_map
        if (i < SYS_SRC) begin : g_sys
            assign src_num[i] = sys_number(i);
            assign src_en[i]  = 1'b1;
            if (i < 2) begin : g_fixed
                assign src_lvl[i] = LVL_W'(i);
            end else begin : g_prog
                assign src_lvl[i] = {2'b00, sys_prio[i-2]} + LVL_W'(2);
            end
        end else begin : g_ext
            assign src_num[i] = NUM_W'(EXT_BASE + i - SYS_SRC);
            assign src_en[i]  = ext_en[i-SYS_SRC];
            assign src_lvl[i] = {2'b00, ext_prio[i-SYS_SRC]} + LVL_W'(2);
        end
    end

    irq_regs #(
        .NUM_EXT   (NUM_EXT),
        .PRIO_BITS (PRIO_BITS)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (reg_we),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .ext_en   (ext_en),
        .ext_prio (ext_prio),
        .sys_prio (sys_prio)
    );

    irq_state #(
        .NSRC  (NSRC),
        .NUM_W (NUM_W)
    ) u_state (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_req    (src_req),
        .src_num    (src_num),
        .ack_valid  (ack_valid),
        .ack_num    (ack_num),
        .done_valid (done_valid),
        .done_num   (done_num),
        .pending    (pending),
        .active     (active)
    );

    irq_pick #(
        .N  (NSRC),
        .W  (LVL_W),
        .IW (IDX_W)
    ) u_pick_pend (
        .cand  (pending & src_en),
        .lvl   (src_lvl),
        .found (sel_found),
        .idx   (sel_idx),
        .best  (sel_lvl)
    );

    irq_pick #(
        .N  (NSRC),
        .W  (LVL_W),
        .IW (IDX_W)
    ) u_pick_act (
        .cand  (active),
        .lvl   (src_lvl),
        .found (act_found),
        .idx   (act_idx),
        .best  (act_lvl)
    );

    assign active_level = act_found ? act_lvl : '1;
    assign offer        = sel_found && (sel_lvl < active_level);

    // Registered request toward the core
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_valid <= 1'b0;
            irq_num   <= '0;
            irq_lvl_q <= '0;
        end else begin
            irq_valid <= offer;
            irq_num   <= offer ? src_num[sel_idx] : '0;
            irq_lvl_q <= sel_lvl;
        end
    end

    // R2: an offered exception number is never zero
    a_r2_num_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> (irq_num != 8'd0));

    // R10: an offered level is strictly more urgent than the active one
    a_r10_strict: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> (irq_lvl_q < $past(active_level)));

    // R4: the chosen source is pending and enabled
    a_r4_sel_eligible: assert property (@(posedge clk) disable iff (!rst_n)
        sel_found |-> (pending[sel_idx] && src_en[sel_idx]));

    // R9: the active level belongs to an active source
    a_r9_level_active: assert property (@(posedge clk) disable iff (!rst_n)
        act_found |-> active[act_idx]);

endmodule

// File: tb/irq_ctrl_tb.sv
module irq_ctrl_tb;

    localparam int NUM_EXT   = 8;
    localparam int PRIO_BITS = 3;
    localparam int NSRC      = 4 + NUM_EXT;
    localparam int IDLE      = (1 << (PRIO_BITS + 2)) - 1;
    localparam int PMASK     = (1 << PRIO_BITS) - 1;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [3:0]           sys_req = '0;
    logic [NUM_EXT-1:0]   ext_req = '0;
    logic                 reg_we = 1'b0;
    logic [7:0]           reg_addr = '0;
    logic [31:0]          reg_wdata = '0;
    logic [31:0]          reg_rdata;
    logic                 ack_valid = 1'b0;
    logic [7:0]           ack_num = '0;
    logic                 done_valid = 1'b0;
    logic [7:0]           done_num = '0;
    logic                 irq_valid;
    logic [7:0]           irq_num;
    logic [PRIO_BITS+1:0] active_level;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  finished = 0;

    bit  m_pend [NSRC];
    bit  m_act  [NSRC];
    bit  m_en   [NUM_EXT];
    int  m_pext [NUM_EXT];
    int  m_psys [2];

    always #10 clk = ~clk;

    irq_ctrl #(.NUM_EXT(NUM_EXT), .PRIO_BITS(PRIO_BITS)) u_dut (
        .clk(clk), .rst_n(rst_n), .sys_req(sys_req), .ext_req(ext_req),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .ack_valid(ack_valid), .ack_num(ack_num),
        .done_valid(done_valid), .done_num(done_num), .irq_valid(irq_valid),
        .irq_num(irq_num), .active_level(active_level)
    );

    function automatic int src_number(int i);
        if (i == 0) return 2;
        if (i == 1) return 3;
        if (i == 2) return 11;
        if (i == 3) return 15;
        return 16 + i - 4;
    endfunction

    function automatic int src_level(int i);
        if (i < 2)  return i;
        if (i < 4)  return m_psys[i-2] + 2;
        return m_pext[i-4] + 2;
    endfunction

    function automatic bit src_ok(int i);
        return (i < 4) ? 1'b1 : m_en[i-4];
    endfunction

    function automatic int exp_active();
        int lv = IDLE;
        for (int i = 0; i < NSRC; i++)
            if (m_act[i] && src_level(i) < lv) lv = src_level(i);
        return lv;
    endfunction

    function automatic int exp_winner();
        int best = -1;
        for (int i = 0; i < NSRC; i++)
            if (m_pend[i] && src_ok(i) && (best < 0 || src_level(i) < src_level(best)))
                best = i;
        if (best >= 0 && src_level(best) < exp_active()) return src_number(best);
        return 0;
    endfunction

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk_eq(string tag, logic [31:0] got, logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    task automatic chk_state(string tag);
        int w = exp_winner();
        n_tests++;
        if (irq_valid !== (w != 0) || irq_num !== 8'(w) || active_level !== (PRIO_BITS+2)'(exp_active())) begin
            n_fail++;
            $display("FAIL %s: valid/num/level got %0d/%0d/%0d expected %0d/%0d/%0d",
                     tag, irq_valid, irq_num, active_level, (w != 0), w, exp_active());
        end
    endtask

    task automatic set_req(int i, logic v);
        if (i < 4) sys_req[i] = v; else ext_req[i-4] = v;
    endtask

    task automatic pulse(int i);
        set_req(i, 1'b1);
        tick(1);
        set_req(i, 1'b0);
        m_pend[i] = 1'b1;
        tick(1);
        tick(2);
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        tick(1);
        reg_we = 1'b0;
        if (a == 8'h00)
            for (int b = 0; b < NUM_EXT; b++) m_en[b] = d[b];
        if (a >= 8'h10 && a < 8'h10 + 8'((NUM_EXT + 3) / 4))
            for (int k = 0; k < 4; k++)
                if (4 * (a - 8'h10) + k < NUM_EXT)
                    m_pext[4 * (a - 8'h10) + k] = (d >> (8 * k)) & PMASK;
        if (a == 8'h60) begin
            m_psys[0] = d & PMASK;
            m_psys[1] = (d >> 8) & PMASK;
        end
        tick(2);
    endtask

    task automatic rd(string tag, logic [7:0] a, logic [31:0] exp);
        reg_addr = a;
        #1;
        chk_eq(tag, reg_rdata, exp);
    endtask

    task automatic do_ack(int num);
        ack_valid = 1'b1; ack_num = 8'(num);
        tick(1);
        ack_valid = 1'b0;
        for (int i = 0; i < NSRC; i++)
            if (src_number(i) == num && m_pend[i]) begin
                m_pend[i] = 1'b0; m_act[i] = 1'b1;
            end
        tick(2);
    endtask

    task automatic do_done(int num);
        done_valid = 1'b1; done_num = 8'(num);
        tick(1);
        done_valid = 1'b0;
        for (int i = 0; i < NSRC; i++)
            if (src_number(i) == num) m_act[i] = 1'b0;
        tick(2);
    endtask

    task automatic drain();
        for (int k = 0; k < 30; k++)
            if (irq_valid) begin
                int n = irq_num;
                do_ack(n);
                do_done(n);
            end
        for (int i = 0; i < NSRC; i++)
            if (m_act[i]) do_done(src_number(i));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < NSRC; i++) begin m_pend[i] = 0; m_act[i] = 0; end
        for (int i = 0; i < NUM_EXT; i++) begin m_en[i] = 0; m_pext[i] = 0; end
        m_psys[0] = 0; m_psys[1] = 0;
        tick(3);
        rst_n = 1'b1;
        tick(1);

        // R1 reset state
        chk_state("R1 reset outputs");
        chk_eq("R1 active level idle", 32'(active_level), 32'(IDLE));
        rd("R1 enable reads zero", 8'h00, 32'h0);
        rd("R1 priority reads zero", 8'h11, 32'h0);

        // R7 register map
        wr(8'h10, 32'hFFFF_FFFF);
        rd("R7 priority fields masked", 8'h10, 32'h0707_0707);
        wr(8'h11, 32'h0302_0100);
        rd("R7 priority word 1", 8'h11, 32'h0302_0100);
        wr(8'h00, 32'hFFFF_FFFF);
        rd("R7 enable lines only", 8'h00, 32'h0000_00FF);
        rd("R7 unmapped reads zero", 8'h20, 32'h0);
        wr(8'h60, 32'h0000_0504);
        rd("R7 system priorities", 8'h60, 32'h0000_0504);
        wr(8'h10, 32'h0);

        // R4 disabled line, then enabled; R2 numbering
        wr(8'h00, 32'h0000_00F7);
        pulse(7);
        chk_eq("R4 disabled line not offered", 32'(irq_valid), 0);
        wr(8'h00, 32'h0000_00FF);
        chk_eq("R2 line 3 is number 19", 32'(irq_num), 19);
        chk_state("R4 enabled pending offered");
        do_ack(19);
        chk_eq("R9 active level after ack", 32'(active_level), 2);
        do_done(19);
        chk_state("R9 done returns idle");

        // R5 tie and R8 reprioritise
        wr(8'h11, 32'h0301_0101);
        pulse(10);
        pulse(9);
        chk_eq("R5 tie lower number wins", 32'(irq_num), 21);
        wr(8'h11, 32'h0300_0101);
        chk_eq("R8 rewrite changes winner", 32'(irq_num), 22);

        // R10 strict preemption and R6 fixed levels
        do_ack(22);
        chk_eq("R10 less urgent waits", 32'(irq_valid), 0);
        wr(8'h11, 32'h0300_0001);
        chk_eq("R10 equal level waits", 32'(irq_valid), 0);
        pulse(2);
        chk_state("R10 system 11 level 6 waits");
        pulse(1);
        chk_eq("R6 fixed level 1 preempts", 32'(irq_num), 3);
        do_ack(3);
        pulse(0);
        chk_eq("R6 fixed level 0 preempts", 32'(irq_num), 2);
        do_ack(2);
        chk_eq("R6 active level zero", 32'(active_level), 0);
        do_done(2);
        do_done(3);
        do_done(22);
        chk_state("R9 nested unwind");
        drain();
        chk_state("R9 drained");

        // R3 held level does not repend; R11 latency
        ext_req[0] = 1'b1;
        tick(1);
        chk_eq("R11 not yet offered after one edge", 32'(irq_valid), 0);
        tick(1);
        m_pend[4] = 1'b1;
        chk_eq("R11 offered after two edges", 32'(irq_num), 16);
        do_ack(16);
        do_done(16);
        tick(3);
        chk_eq("R3 held level not repended", 32'(irq_valid), 0);
        ext_req[0] = 1'b0;
        tick(1);
        pulse(4);
        chk_eq("R3 new edge pends again", 32'(irq_num), 16);
        drain();

        // Random mix against the reference model
        for (int it = 0; it < 400; it++) begin
            int op = $urandom % 6;
            case (op)
                0, 1: pulse($urandom % NSRC);
                2: wr(8'h10 + 8'($urandom % 2), $urandom);
                3: begin
                    if ($urandom % 2) wr(8'h60, $urandom);
                    else wr(8'h00, $urandom | 32'h11);
                end
                4: if (irq_valid) do_ack(irq_num); else tick(1);
                default: begin
                    int j = $urandom % NSRC;
                    if (m_act[j]) do_done(src_number(j)); else tick(1);
                end
            endcase
            chk_state("R5 R6 R9 R10 random arbitration");
        end

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule